// File: doc/BRIEF.md
# Multi-layer AHB bus matrix

This block is a crossbar that connects several AHB-Lite masters to several AHB-Lite slaves. The default build has two masters and three slaves. Every master owns a private layer: an input stage that can park an address phase, a decoder that turns the transfer address into a target, and a return path that routes read data, ready and response from that target back to the master. Every slave owns an output stage with its own fixed-priority arbiter and an address/write-data multiplexer.

Masters that address different slaves move in the same cycle with no added wait; they are serialised only when they compete for one slave. A master that loses is held off with ready low while its address phase waits in its input stage. It is presented to the slave as soon as the current owner's data phase ends. Addresses outside the map go to a default responder inside each layer, which answers with a two-cycle ERROR. Transfers are single transfers with wait states; bursts that lock the arbiter, split and retry are not handled.

Top module: `ahbx_matrix`

## Requirements
- R1: Address bits [31:12] select the target. A value of j (0, 1 or 2) selects slave j, whose region is j*0x1000 to j*0x1000+0xFFF. Any other value selects the default responder. A slave receives only NONSEQ/SEQ address phases whose region is its own.
- R2: When both masters request the same slave at a transfer boundary, master 0 is granted and master 1 waits.
- R3: Masters targeting different slaves are both presented in the same cycle. With zero-wait slaves, each master's data phase lasts one cycle.
- R4: A slave inserting w wait states gives a data phase of w+1 cycles at the master. Write data reaches the addressed slave and read data returns to the requesting master.
- R5: A master that loses arbitration sees ready low on the following cycle. Ready stays low until it is granted and the slave completes. Against an owner with w waits that started in the same cycle, its data phase lasts 2(w+1) cycles.
- R6: Arbitration changes only at a transfer boundary. A request made while another master's data phase on that slave is stalled waits for it, even at higher priority. For a request one cycle after an owner with w waits, this takes 2w+1 cycles.
- R7: A non-IDLE access to an unmapped address is answered with HRESP=1 (ERROR) for two cycles: ready low in the first and high in the second.
- R8: An IDLE (00) or BUSY (01) transfer from a master gives ready high and HRESP=0 (OKAY) on the next cycle, and selects no slave.
- R9: After reset all masters see ready high and OKAY, and no slave is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_haddr | input | NM x AW | Master address |
| m_htrans | input | NM x 2 | Master transfer type (00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ) |
| m_hwrite | input | NM | Master write flag |
| m_hwdata | input | NM x DW | Master write data |
| m_hrdata | output | NM x DW | Read data to master |
| m_hready | output | NM | Transfer done / ready to master |
| m_hresp | output | NM | Response to master (1 = ERROR) |
| s_hsel | output | NS | Slave select |
| s_haddr | output | NS x AW | Slave address |
| s_htrans | output | NS x 2 | Slave transfer type |
| s_hwrite | output | NS | Slave write flag |
| s_hwdata | output | NS x DW | Slave write data |
| s_hrdata | input | NS x DW | Slave read data |
| s_hready | input | NS | Slave ready output |
| s_hresp | input | NS | Slave response |

## Verification
Two things can land in one cycle: arbitration on a slave and an address phase from the other layer. In the first case both masters issue in the same cycle. If they target different slaves they must both finish without a wait. If they target the same slave, master 1 must be parked, and its data-phase length is judged against 2(w+1). In the second case a higher-priority request arrives one cycle into a stalled data phase of the lower master. It must wait exactly 2w+1 cycles. An unmapped access from one master beside a normal access from the other checks that the error sequence and the concurrent transfer do not disturb each other.

// File: rtl/ahbx_pkg.sv
package ahbx_pkg;

   typedef enum logic [1:0] {
      TR_IDLE = 2'b00,
      TR_BUSY = 2'b01,
      TR_NSEQ = 2'b10,
      TR_SEQ  = 2'b11
   } htrans_e;

   typedef enum logic [1:0] {
      DEF_NONE = 2'b00,
      DEF_ERR1 = 2'b01,
      DEF_ERR2 = 2'b10
   } def_st_e;

endpackage

// File: rtl/ahbx_layer.sv
module ahbx_layer
   import ahbx_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int NS    = 3,
   parameter int RGN_W = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          m_haddr,
   input  logic [1:0]             m_htrans,
   input  logic                   m_hwrite,
   output logic [DW-1:0]          m_hrdata,
   output logic                   m_hready,
   output logic                   m_hresp,
   input  logic [NS-1:0]          slv_acc,
   input  logic [NS-1:0]          slv_rdy,
   input  logic [NS-1:0]          slv_rsp,
   input  logic [NS-1:0][DW-1:0]  slv_rdata,
   output logic [NS-1:0]          req_sel,
   output logic [AW-1:0]          req_addr,
   output logic [1:0]             req_trans,
   output logic                   req_write
);
   localparam int IW = AW - RGN_W;

   // input stage: parked address phase
   logic          hold_q;
   logic [AW-1:0] hold_addr_q;
   logic [1:0]    hold_trans_q;
   logic          hold_write_q;

   logic          live, req_vld, hit_def, def_acc, acc_any;
   logic [IW-1:0] rgn;

   // data phase tracking
   logic [NS-1:0] dp_slv_q;
   def_st_e       def_q;

   assign live      = m_htrans[1] & m_hready;
   assign req_vld   = hold_q | live;
   assign req_addr  = hold_q ? hold_addr_q  : m_haddr;
   assign req_trans = hold_q ? hold_trans_q : m_htrans;
   assign req_write = hold_q ? hold_write_q : m_hwrite;

   // decode stage
   assign rgn     = req_addr[AW-1:RGN_W];
   assign hit_def = (rgn >= IW'(NS));

   for (genvar j = 0; j < NS; j++) begin : g_dec
      assign req_sel[j] = req_vld & (rgn == IW'(j));
   end

   assign def_acc = req_vld & hit_def;
   assign acc_any = (|slv_acc) | def_acc;

   // return path
   always_comb begin
      m_hrdata = '0;
      m_hresp  = (def_q != DEF_NONE);
      for (int j = 0; j < NS; j++) begin
         if (dp_slv_q[j]) begin
            m_hrdata = m_hrdata | slv_rdata[j];
            m_hresp  = m_hresp | slv_rsp[j];
         end
      end
      if (hold_q)
         m_hready = 1'b0;
      else if (|dp_slv_q)
         m_hready = |(dp_slv_q & slv_rdy);
      else
         m_hready = (def_q != DEF_ERR1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q       <= 1'b0;
         hold_addr_q  <= '0;
         hold_trans_q <= TR_IDLE;
         hold_write_q <= 1'b0;
      end else if (acc_any) begin
         hold_q <= 1'b0;
      end else if (live) begin
         hold_q       <= 1'b1;
         hold_addr_q  <= m_haddr;
         hold_trans_q <= m_htrans;
         hold_write_q <= m_hwrite;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_slv_q <= '0;
         def_q    <= DEF_NONE;
      end else if (acc_any) begin
         dp_slv_q <= req_sel;
         def_q    <= def_acc ? DEF_ERR1 : DEF_NONE;
      end else if (m_hready) begin
         dp_slv_q <= '0;
         def_q    <= DEF_NONE;
      end else if (def_q == DEF_ERR1) begin
         def_q <= DEF_ERR2;
      end
   end

endmodule

// File: rtl/ahbx_port.sv
module ahbx_port
   import ahbx_pkg::*;
#(
   parameter int NM           = 2,
   parameter int AW           = 32,
   parameter int DW           = 32,
   parameter bit LOW_IDX_WINS = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NM-1:0]          rq,
   input  logic [NM-1:0][AW-1:0]  req_addr,
   input  logic [NM-1:0][1:0]     req_trans,
   input  logic [NM-1:0]          req_write,
   input  logic [NM-1:0][DW-1:0]  m_hwdata,
   input  logic                   s_hready,
   output logic [NM-1:0]          gnt,
   output logic                   s_hsel,
   output logic [AW-1:0]          s_haddr,
   output logic [1:0]             s_htrans,
   output logic                   s_hwrite,
   output logic [DW-1:0]          s_hwdata
);
   logic [NM-1:0] own_q;

   // fixed-priority arbiter, direction chosen by parameter
   if (LOW_IDX_WINS) begin : g_lo
      always_comb begin
         gnt = '0;
         for (int m = NM - 1; m >= 0; m--)
            if (rq[m]) gnt = NM'(1) << m;
      end
   end else begin : g_hi
      always_comb begin
         gnt = '0;
         for (int m = 0; m < NM; m++)
            if (rq[m]) gnt = NM'(1) << m;
      end
   end

   assign s_hsel = |gnt;

   always_comb begin
      s_haddr  = '0;
      s_htrans = TR_IDLE;
      s_hwrite = 1'b0;
      s_hwdata = '0;
      for (int m = 0; m < NM; m++) begin
         if (gnt[m]) begin
            s_haddr  = s_haddr | req_addr[m];
            s_htrans = s_htrans | req_trans[m];
            s_hwrite = s_hwrite | req_write[m];
         end
         if (own_q[m])
            s_hwdata = s_hwdata | m_hwdata[m];
      end
   end

   // data phase owner for write data steering
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         own_q <= '0;
      else if (s_hready)
         own_q <= gnt;
   end

endmodule

// File: rtl/ahbx_matrix.sv
module ahbx_matrix
   import ahbx_pkg::*;
#(
   parameter int NM           = 2,
   parameter int NS           = 3,
   parameter int AW           = 32,
   parameter int DW           = 32,
   parameter int RGN_W        = 12,
   parameter bit LOW_IDX_WINS = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NM-1:0][AW-1:0]  m_haddr,
   input  logic [NM-1:0][1:0]     m_htrans,
   input  logic [NM-1:0]          m_hwrite,
   input  logic [NM-1:0][DW-1:0]  m_hwdata,
   output logic [NM-1:0][DW-1:0]  m_hrdata,
   output logic [NM-1:0]          m_hready,
   output logic [NM-1:0]          m_hresp,
   output logic [NS-1:0]          s_hsel,
   output logic [NS-1:0][AW-1:0]  s_haddr,
   output logic [NS-1:0][1:0]     s_htrans,
   output logic [NS-1:0]          s_hwrite,
   output logic [NS-1:0][DW-1:0]  s_hwdata,
   input  logic [NS-1:0][DW-1:0]  s_hrdata,
   input  logic [NS-1:0]          s_hready,
   input  logic [NS-1:0]          s_hresp
);
   if (NM < 1 || NS < 1) begin : g_bad_count
      $error("ahbx_matrix: NM and NS must be at least 1");
   end
   if (RGN_W < 2 || RGN_W >= AW) begin : g_bad_rgn
      $error("ahbx_matrix: RGN_W out of range");
   end
   if (DW % 8 != 0) begin : g_bad_dw
      $error("ahbx_matrix: DW must be whole bytes");
   end

   logic [NM-1:0][NS-1:0] req_sel;
   logic [NM-1:0][AW-1:0] req_addr;
   logic [NM-1:0][1:0]    req_trans;
   logic [NM-1:0]         req_write;
   logic [NM-1:0][NS-1:0] acc;
   logic [NS-1:0][NM-1:0] rq_s;
   logic [NS-1:0][NM-1:0] gnt_s;

   for (genvar m = 0; m < NM; m++) begin : g_xpose_m
      for (genvar j = 0; j < NS; j++) begin : g_xpose_s
         assign rq_s[j][m] = req_sel[m][j];
         assign acc[m][j]  = gnt_s[j][m] & s_hready[j];
      end
   end

   for (genvar m = 0; m < NM; m++) begin : g_layer
      ahbx_layer #(.AW(AW), .DW(DW), .NS(NS), .RGN_W(RGN_W)) layer_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .m_haddr   (m_haddr[m]),
         .m_htrans  (m_htrans[m]),
         .m_hwrite  (m_hwrite[m]),
         .m_hrdata  (m_hrdata[m]),
         .m_hready  (m_hready[m]),
         .m_hresp   (m_hresp[m]),
         .slv_acc   (acc[m]),
         .slv_rdy   (s_hready),
         .slv_rsp   (s_hresp),
         .slv_rdata (s_hrdata),
         .req_sel   (req_sel[m]),
         .req_addr  (req_addr[m]),
         .req_trans (req_trans[m]),
         .req_write (req_write[m])
      );
   end

   for (genvar j = 0; j < NS; j++) begin : g_port
      ahbx_port #(.NM(NM), .AW(AW), .DW(DW), .LOW_IDX_WINS(LOW_IDX_WINS)) port_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .rq        (rq_s[j]),
         .req_addr  (req_addr),
         .req_trans (req_trans),
         .req_write (req_write),
         .m_hwdata  (m_hwdata),
         .s_hready  (s_hready[j]),
         .gnt       (gnt_s[j]),
         .s_hsel    (s_hsel[j]),
         .s_haddr   (s_haddr[j]),
         .s_htrans  (s_htrans[j]),
         .s_hwrite  (s_hwrite[j]),
         .s_hwdata  (s_hwdata[j])
      );
   end

endmodule

// File: rtl/ahbx_matrix_chk.sv
module ahbx_matrix_chk
   import ahbx_pkg::*;
#(
   parameter int NM    = 2,
   parameter int NS    = 3,
   parameter int AW    = 32,
   parameter int RGN_W = 12
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NM-1:0][1:0]     m_htrans,
   input logic [NM-1:0]          m_hready,
   input logic [NM-1:0]          m_hresp,
   input logic [NS-1:0]          s_hsel,
   input logic [NS-1:0][1:0]     s_htrans,
   input logic [NS-1:0][AW-1:0]  s_haddr,
   input logic [NM-1:0][NS-1:0]  req_sel,
   input logic [NM-1:0][AW-1:0]  req_addr,
   input logic [NM-1:0][NS-1:0]  acc
);
   for (genvar j = 0; j < NS; j++) begin : g_s
      // R1
      dec_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (s_hsel[j] && (s_htrans[j] inside {TR_NSEQ, TR_SEQ}))
         |-> (s_haddr[j][AW-1:RGN_W] == (AW-RGN_W)'(j)));

      if (NM >= 2) begin : g_pri
         // R2
         pri_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_sel[0][j] && req_sel[1][j]) |-> (s_haddr[j] == req_addr[0]));
      end

      for (genvar k = 0; k < NS; k++) begin : g_k
         if (NM >= 2 && k != j) begin : g_par
            // R3
            par_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (req_sel[0][j] && req_sel[1][k]) |-> (s_hsel[j] && s_hsel[k]));
         end
      end
   end

   for (genvar m = 0; m < NM; m++) begin : g_m
      // R5
      lose_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|(req_sel[m] & ~acc[m])) |=> !m_hready[m]);

      // R7
      err_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (m_hresp[m] && !m_hready[m]) |=> (m_hresp[m] && m_hready[m]));

      // R8
      idle_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (m_hready[m] && (m_htrans[m] inside {TR_IDLE, TR_BUSY}))
         |=> (m_hready[m] && !m_hresp[m]));
   end

endmodule

bind ahbx_matrix ahbx_matrix_chk #(
   .NM(NM), .NS(NS), .AW(AW), .RGN_W(RGN_W)
) chk_i (.*);

// File: tb/ahbx_matrix_tb_top.sv
module ahbx_matrix_tb_top;
   localparam int CLK_NS = 10;
   localparam int NM = 2;
   localparam int NS = 3;
   localparam int AW = 32;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   logic [NM-1:0][AW-1:0] m_haddr;
   logic [NM-1:0][1:0]    m_htrans;
   logic [NM-1:0]         m_hwrite;
   logic [NM-1:0][DW-1:0] m_hwdata;
   logic [NM-1:0][DW-1:0] m_hrdata;
   logic [NM-1:0]         m_hready;
   logic [NM-1:0]         m_hresp;
   logic [NS-1:0]         s_hsel;
   logic [NS-1:0][AW-1:0] s_haddr;
   logic [NS-1:0][1:0]    s_htrans;
   logic [NS-1:0]         s_hwrite;
   logic [NS-1:0][DW-1:0] s_hwdata;
   logic [NS-1:0][DW-1:0] s_hrdata;
   logic [NS-1:0]         s_hready;
   logic [NS-1:0]         s_hresp;

   ahbx_matrix #(.NM(NM), .NS(NS), .AW(AW), .DW(DW)) dut_i (.*);

   // slave models: 16-word memory, programmable wait states
   logic [NS-1:0]   sdp, swr;
   int              scnt [NS];
   int              wst  [NS];
   logic [3:0]      sla  [NS];
   logic [DW-1:0]   smem [NS][16];

   always_comb begin
      for (int j = 0; j < NS; j++) begin
         s_hready[j] = !(sdp[j] && scnt[j] > 0);
         s_hrdata[j] = sdp[j] ? smem[j][sla[j]] : '0;
         s_hresp[j]  = 1'b0;
      end
   end

   always @(posedge clk) begin
      for (int j = 0; j < NS; j++) begin
         if (!rst_n) begin
            sdp[j]  <= 1'b0;
            swr[j]  <= 1'b0;
            scnt[j] <= 0;
            sla[j]  <= '0;
            for (int a = 0; a < 16; a++) smem[j][a] <= '0;
         end else begin
            if (sdp[j] && scnt[j] == 0) begin
               if (swr[j]) smem[j][sla[j]] <= s_hwdata[j];
               sdp[j] <= 1'b0;
            end else if (sdp[j]) begin
               scnt[j] <= scnt[j] - 1;
            end
            if (s_hsel[j] && s_htrans[j][1] && s_hready[j]) begin
               sdp[j]  <= 1'b1;
               scnt[j] <= wst[j];
               sla[j]  <= s_haddr[j][5:2];
               swr[j]  <= s_hwrite[j];
            end
         end
      end
   end

   int total = 0;
   int bad = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xfer(input int m, input logic [AW-1:0] a, input logic w,
                       input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                       output logic rsp, output int n, output logic f_rdy,
                       output logic f_rsp);
      @(negedge clk);
      m_haddr[m]  = a;
      m_htrans[m] = 2'b10;
      m_hwrite[m] = w;
      #1;
      while (!m_hready[m]) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      m_htrans[m] = 2'b00;
      m_hwdata[m] = wd;
      #1;
      n = 1;
      f_rdy = m_hready[m];
      f_rsp = m_hresp[m];
      while (!m_hready[m]) begin
         @(negedge clk);
         #1;
         n++;
      end
      rd  = m_hrdata[m];
      rsp = m_hresp[m];
   endtask

   initial begin
      #(CLK_NS * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd0, rd1, exp0, exp1;
      logic r0, r1, fr0, fr1, fs0, fs1;
      int n0, n1;
      logic [AW-1:0] ad0, ad1;

      m_haddr  = '0;
      m_htrans = '0;
      m_hwrite = '0;
      m_hwdata = '0;
      for (int j = 0; j < NS; j++) wst[j] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R9 reset state
      chk(m_hready == 2'b11, "R9 ready", m_hready, 3);
      chk(m_hresp == 2'b00, "R9 resp", m_hresp, 0);
      chk(s_hsel == '0, "R9 hsel", s_hsel, 0);

      // R1 R4 sweep: every master, slave and wait count
      for (int m = 0; m < NM; m++) begin
         for (int j = 0; j < NS; j++) begin
            for (int w = 0; w < 3; w++) begin
               wst[j] = w;
               ad0  = AW'(j * 4096 + ((m * 3 + w) % 16) * 4);
               exp0 = 32'hA000_0000 + DW'(m * 256 + j * 16 + w);
               xfer(m, ad0, 1'b1, exp0, rd0, r0, n0, fr0, fs0);
               chk(n0 == w + 1, "R4 write len", n0, w + 1);
               chk(r0 == 1'b0, "R4 write resp", r0, 0);
               xfer(m, ad0, 1'b0, '0, rd0, r0, n0, fr0, fs0);
               chk(n0 == w + 1, "R4 read len", n0, w + 1);
               chk(rd0 == exp0, "R1 read data", rd0, exp0);
            end
            wst[j] = 0;
         end
      end

      // R7 unmapped accesses
      xfer(0, 32'h0000_3000, 1'b0, '0, rd0, r0, n0, fr0, fs0);
      chk(r0 == 1'b1 && n0 == 2, "R7 err len", n0, 2);
      chk(fr0 == 1'b0 && fs0 == 1'b1, "R7 err first", {fr0, fs0}, 1);
      xfer(1, 32'h8000_0010, 1'b1, 32'h5, rd0, r0, n0, fr0, fs0);
      chk(r0 == 1'b1 && n0 == 2, "R7 err high addr", n0, 2);

      // R8 idle transfer
      @(negedge clk);
      m_haddr[0]  = 32'h0000_1000;
      m_htrans[0] = 2'b00;
      m_haddr[1]  = 32'h0000_2000;
      m_htrans[1] = 2'b01;
      @(negedge clk);
      #1;
      chk(m_hready == 2'b11 && m_hresp == 2'b00, "R8 idle okay", {m_hready, m_hresp}, 12);
      chk(s_hsel == '0, "R8 idle no sel", s_hsel, 0);

      // R3 different slaves in the same cycle
      fork
         xfer(0, 32'h0000_0040, 1'b1, 32'h1111, rd0, r0, n0, fr0, fs0);
         xfer(1, 32'h0000_1040, 1'b1, 32'h2222, rd1, r1, n1, fr1, fs1);
      join
      chk(n0 == 1 && n1 == 1, "R3 concurrent len", {n0[7:0], n1[7:0]}, 16'h0101);
      fork
         xfer(0, 32'h0000_1040, 1'b0, '0, rd0, r0, n0, fr0, fs0);
         xfer(1, 32'h0000_0040, 1'b0, '0, rd1, r1, n1, fr1, fs1);
      join
      chk(rd0 == 32'h2222 && rd1 == 32'h1111, "R3 crossed reads", {rd0, rd1}, 64'h2222_0000_1111);

      // R7 R3 error beside a normal transfer
      fork
         xfer(0, 32'h0004_0000, 1'b0, '0, rd0, r0, n0, fr0, fs0);
         xfer(1, 32'h0000_0080, 1'b0, '0, rd1, r1, n1, fr1, fs1);
      join
      chk(n0 == 2 && r0 == 1'b1, "R7 err beside xfer", n0, 2);
      chk(n1 == 1 && r1 == 1'b0, "R3 xfer beside err", n1, 1);

      // R2 R5 contention on slave 2
      for (int w = 0; w < 3; w++) begin
         wst[2] = w;
         ad0  = AW'(32'h2000 + w * 8);
         ad1  = AW'(32'h2004 + w * 8);
         exp0 = 32'hC0DE_0000 + DW'(w);
         exp1 = 32'hBEEF_0000 + DW'(w);
         fork
            xfer(0, ad0, 1'b1, exp0, rd0, r0, n0, fr0, fs0);
            xfer(1, ad1, 1'b1, exp1, rd1, r1, n1, fr1, fs1);
         join
         chk(n0 == w + 1, "R2 winner len", n0, w + 1);
         chk(n1 == 2 * (w + 1), "R5 loser len", n1, 2 * (w + 1));
         chk(fr1 == 1'b0, "R5 loser ready low", fr1, 0);
         xfer(0, ad1, 1'b0, '0, rd0, r0, n0, fr0, fs0);
         chk(rd0 == exp1, "R5 loser write landed", rd0, exp1);
         xfer(1, ad0, 1'b0, '0, rd1, r1, n1, fr1, fs1);
         chk(rd1 == exp0, "R2 winner write landed", rd1, exp0);
      end

      // R6 no preemption of a stalled owner
      wst[2] = 2;
      fork
         xfer(1, 32'h0000_2030, 1'b0, '0, rd1, r1, n1, fr1, fs1);
         begin
            @(negedge clk);
            xfer(0, 32'h0000_2034, 1'b0, '0, rd0, r0, n0, fr0, fs0);
         end
      join
      chk(n1 == 3, "R6 owner len", n1, 3);
      chk(n0 == 5, "R6 late high pri len", n0, 5);
      wst[2] = 0;

      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule